// File: doc/BRIEF.md
# Latched-Address One-Time-Programmable Word Store

This block models a 2048-word by 8-bit store whose cells can be set once. Every cell leaves reset at the value given by an initial image parameter, which is all zeros by default. A cell can later be raised from 0 to 1, one bit per request, and can never go back. The cells are laid out as a 128 by 128 matrix. The seven high address bits pick a row. The four low address bits pick one of sixteen column positions inside each of the eight bit-slices of that row.

Reads and programming both work on a captured address, not on the live address pins. While the active-low chip select is high, the address register follows the pins. When the chip select goes low, the register holds its value until the select goes high again. The read data comes with a valid flag that stands in for three-state pads: the flag is high only during an access with the output enable low and the program-enable input high.

A program request is accepted only while the outputs are disabled and program-enable is low. A rejected request leaves the store unchanged and pulses an error flag.

Top module: `otp_latched_rom`

## Requirements
- R1: After reset, `dout_vld` and `prog_err` are 0 and every word reads back its value from `INIT_IMAGE`, even if it was programmed before that reset.
- R2: The captured address is the value of `addr` at the last rising clock edge at which `ce_n` was 1. Changes on `addr` while `ce_n` stays low do not change `dout`.
- R3: Bit b of the word at address a is stored at `INIT_IMAGE` index a[10:4]*128 + b*16 + a[3:0].
- R4: `dout_vld` is 1 exactly when `ce_n` was 0 at the previous rising edge, `oe_n` is 0 and `prog_n` is 1. It follows `oe_n` and `prog_n` in the same cycle.
- R5: `dout` is all zeros whenever `dout_vld` is 0. When `dout_vld` is 1, `dout` is the word at the captured address.
- R6: A `prog_req` sampled with `oe_n`=1, `prog_n`=0 and exactly one bit set in `prog_mask` sets that bit of the word at the captured address to 1. The new value can be read at the next access.
- R7: Programming never clears a bit and never touches other bits or other words. Requesting a bit that is already 1 is accepted and changes nothing.
- R8: A request whose `prog_mask` has zero bits set, or two or more bits set, is rejected and changes no word.
- R9: A request sampled with `oe_n`=0 or with `prog_n`=1 is rejected and changes no word.
- R10: `prog_err` is 1 for exactly the one cycle after the edge that sampled a rejected request, and 0 after accepted requests and when no request was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce_n | input | 1 | Active-low chip select; its high-to-low step captures the address |
| oe_n | input | 1 | Active-low output enable |
| prog_n | input | 1 | Program enable: low to program, high to read |
| addr | input | 11 | Word address |
| prog_req | input | 1 | Program request strobe |
| prog_mask | input | 8 | Bit to set in the captured word (must be one-hot) |
| dout | output | 8 | Read data, zero when not valid |
| dout_vld | output | 1 | Read data valid (stands in for enabled pads) |
| prog_err | output | 1 | One-cycle pulse after a rejected program request |

## Verification
An address register that follows the pins while it should hold, or that captures on the wrong edge, shows up on the first read after an address change: the word from the wrong address appears on `dout` in the same cycle. A wrong bit-to-column mapping, or a write that spreads into nearby bits, shows up at the next read of the affected or neighbouring word. The bench programs neighbours along both the row and the column axis to expose this. A wrong gating decision shows on `prog_err` one edge after the request, and a lost write shows at the read that follows.

// File: rtl/otp_pkg.sv
package otp_pkg;

  // Outcome of a sampled program request.
  typedef enum logic [1:0] {
    PRG_IDLE   = 2'd0,
    PRG_ACCEPT = 2'd1,
    PRG_REJECT = 2'd2
  } prg_decision_e;

  // Number of set bits in a mask of up to 32 bits.
  function automatic int unsigned bit_count(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/otp_addr_latch.sv
module otp_addr_latch #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] cap_addr,
  output logic              access
);
  logic [ADDR_W-1:0] cap_d, cap_q;
  logic              acc_d, acc_q;
  logic              cap_en;

  // Register follows the pins while select is high, holds while it is low.
  always_comb begin
    cap_en = ce_n;
    cap_d  = cap_en ? addr : cap_q;
    acc_d  = ~ce_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      acc_q <= 1'b0;
    end else begin
      cap_q <= cap_d;
      acc_q <= acc_d;
    end
  end

  assign cap_addr = cap_q;
  assign access   = acc_q;
endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_req,
  input  logic [WORD_W-1:0] prog_mask,
  input  logic              oe_n,
  input  logic              prog_n,
  output logic              wr_en,
  output logic              err
);
  prg_decision_e decision;
  logic          mask_ok;
  logic          gate_ok;
  logic          err_d, err_q;

  always_comb begin
    mask_ok = (bit_count(32'(prog_mask)) == 1);
    gate_ok = oe_n & ~prog_n;
    if (!prog_req)              decision = PRG_IDLE;
    else if (mask_ok && gate_ok) decision = PRG_ACCEPT;
    else                        decision = PRG_REJECT;
    wr_en = (decision == PRG_ACCEPT);
    err_d = (decision == PRG_REJECT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err = err_q;
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int ROW_BITS = 7,
  parameter int COL_BITS = 4,
  parameter int WORD_W   = 8,
  parameter logic [(2**ROW_BITS)*(WORD_W*(2**COL_BITS))-1:0] INIT_IMAGE = '0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ROW_BITS+COL_BITS-1:0] acc_addr,
  input  logic                         wr_en,
  input  logic [WORD_W-1:0]            wr_mask,
  output logic [WORD_W-1:0]            rd_word
);
  localparam int ROWS   = 2**ROW_BITS;
  localparam int GROUPS = 2**COL_BITS;
  localparam int COLS   = WORD_W*GROUPS;

  logic [COLS-1:0]     rows_q [ROWS];
  logic [ROW_BITS-1:0] row_sel;
  logic [COL_BITS-1:0] col_sel;
  logic [COLS-1:0]     cur_row;
  logic [COLS-1:0]     set_bits;
  logic [COLS-1:0]     row_d;

  assign row_sel = acc_addr[ROW_BITS+COL_BITS-1:COL_BITS];
  assign col_sel = acc_addr[COL_BITS-1:0];
  assign cur_row = rows_q[row_sel];

  // Data bit b lives in slice b, column col_sel within the slice.
  for (genvar b = 0; b < WORD_W; b++) begin : g_slice
    logic [GROUPS-1:0] slice_set;
    always_comb begin
      slice_set = '0;
      slice_set[col_sel] = wr_mask[b];
    end
    assign set_bits[b*GROUPS +: GROUPS] = slice_set;
    assign rd_word[b] = cur_row[b*GROUPS + int'(col_sel)];
  end

  // Cells only ever move from 0 to 1.
  assign row_d = cur_row | set_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) rows_q[r] <= INIT_IMAGE[r*COLS +: COLS];
    end else if (wr_en) begin
      rows_q[row_sel] <= row_d;
    end
  end
endmodule

// File: rtl/otp_latched_rom.sv
module otp_latched_rom #(
  parameter int ROW_BITS = 7,
  parameter int COL_BITS = 4,
  parameter int WORD_W   = 8,
  parameter int ADDR_W   = ROW_BITS + COL_BITS,
  parameter logic [(2**ROW_BITS)*(WORD_W*(2**COL_BITS))-1:0] INIT_IMAGE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              prog_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              prog_req,
  input  logic [WORD_W-1:0] prog_mask,
  output logic [WORD_W-1:0] dout,
  output logic              dout_vld,
  output logic              prog_err
);
  logic [1:0]        rst_pipe_q;
  logic              rst_core_n;
  logic [ADDR_W-1:0] cap_addr;
  logic              access;
  logic              wr_en;
  logic [WORD_W-1:0] word;
  logic              drive;

  // Reset asserts at once and is released through two flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  otp_addr_latch #(.ADDR_W(ADDR_W)) latch_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .ce_n     (ce_n),
    .addr     (addr),
    .cap_addr (cap_addr),
    .access   (access)
  );

  otp_prog_ctrl #(.WORD_W(WORD_W)) prog_i (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .prog_req  (prog_req),
    .prog_mask (prog_mask),
    .oe_n      (oe_n),
    .prog_n    (prog_n),
    .wr_en     (wr_en),
    .err       (prog_err)
  );

  otp_cell_array #(
    .ROW_BITS   (ROW_BITS),
    .COL_BITS   (COL_BITS),
    .WORD_W     (WORD_W),
    .INIT_IMAGE (INIT_IMAGE)
  ) array_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .acc_addr (cap_addr),
    .wr_en    (wr_en),
    .wr_mask  (prog_mask),
    .rd_word  (word)
  );

  assign drive    = access & ~oe_n & prog_n;
  assign dout_vld = drive;
  assign dout     = drive ? word : '0;
endmodule

// File: rtl/otp_latched_rom_chk.sv
module otp_latched_rom_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              prog_req,
  input logic [WORD_W-1:0] prog_mask,
  input logic [WORD_W-1:0] dout,
  input logic              dout_vld,
  input logic              prog_err
);
  // R2: a held access with outputs on keeps the same word
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_vld && $past(dout_vld)) |-> $stable(dout));

  // R4: select high at the previous edge means no valid data
  assert_vld_needs_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n) |-> !dout_vld);

  // R5: data is zero while not valid
  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_vld |-> (dout == '0));

  // R8: a mask that is not one-hot is rejected
  assert_mask_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && ($countones(prog_mask) != 1)) |=> prog_err);

  // R9: a request with outputs enabled is rejected
  assert_oe_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && !oe_n) |=> prog_err);

  // R10: no error pulse without a request one edge earlier
  assert_err_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_req |=> !prog_err);
endmodule

bind otp_latched_rom otp_latched_rom_chk #(.WORD_W(WORD_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .ce_n      (ce_n),
  .oe_n      (oe_n),
  .prog_req  (prog_req),
  .prog_mask (prog_mask),
  .dout      (dout),
  .dout_vld  (dout_vld),
  .prog_err  (prog_err)
);

// File: tb/otp_latched_rom_tb.sv
module otp_latched_rom_tb_top;
  localparam int CLK_PERIOD = 10;
  // Word 0x005 bit 0 -> index 5; word 0x7FF bit 7 -> index 127*128+7*16+15 = 16383 (R3)
  localparam logic [16383:0] TB_INIT = {1'b1, {16377{1'b0}}, 1'b1, 5'b0};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n, oe_n, prog_n, prog_req;
  logic [10:0] addr;
  logic [7:0]  prog_mask;
  logic [7:0]  dout;
  logic        dout_vld, prog_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_latched_rom #(.INIT_IMAGE(TB_INIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .prog_n(prog_n),
    .addr(addr), .prog_req(prog_req), .prog_mask(prog_mask),
    .dout(dout), .dout_vld(dout_vld), .prog_err(prog_err)
  );

  // {addr[11], mask[8], oe_n[1], prog_n[1], exp_err[1], exp_word[8]}
  localparam int NV = 12;
  localparam logic [29:0] VEC [NV] = '{
    {11'h123, 8'h01, 1'b1, 1'b0, 1'b0, 8'h01},  // R6
    {11'h123, 8'h80, 1'b1, 1'b0, 1'b0, 8'h81},  // R6 R7
    {11'h123, 8'h01, 1'b1, 1'b0, 1'b0, 8'h81},  // R7 already set
    {11'h123, 8'h03, 1'b1, 1'b0, 1'b1, 8'h81},  // R8 two bits
    {11'h123, 8'h00, 1'b1, 1'b0, 1'b1, 8'h81},  // R8 no bit
    {11'h123, 8'h04, 1'b0, 1'b0, 1'b1, 8'h81},  // R9 outputs enabled
    {11'h123, 8'h04, 1'b1, 1'b1, 1'b1, 8'h81},  // R9 program-enable high
    {11'h7FF, 8'h01, 1'b1, 1'b0, 1'b0, 8'h81},  // R6 on preset word
    {11'h005, 8'h02, 1'b1, 1'b0, 1'b0, 8'h03},  // R6 on preset word
    {11'h124, 8'h10, 1'b1, 1'b0, 1'b0, 8'h10},  // R7 column neighbour
    {11'h133, 8'h20, 1'b1, 1'b0, 1'b0, 8'h20},  // R7 row neighbour
    {11'h123, 8'h40, 1'b1, 1'b0, 1'b0, 8'hC1}   // R6 R7
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive address with select high, then drop select and scramble the pins (R2).
  task automatic capture(input logic [10:0] a);
    ce_n = 1'b1; addr = a;
    @(negedge clk);
    ce_n = 1'b0; addr = ~a;
    @(negedge clk);
  endtask

  task automatic read_word(output logic [7:0] w, output logic v);
    oe_n = 1'b0; prog_n = 1'b1;
    #1;
    w = dout; v = dout_vld;
    oe_n = 1'b1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; prog_n = 1'b1;
    prog_req = 1'b0; prog_mask = '0; addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [7:0] w;
    logic v;
    do_reset();
    // R1 reset state
    check("R1 vld", {7'b0, dout_vld}, 8'h00);
    check("R1 err", {7'b0, prog_err}, 8'h00);
    // R3 preset image mapping
    capture(11'h7FF); read_word(w, v);
    check("R3 word 7FF", w, 8'h80);
    check("R4 vld on access", {7'b0, v}, 8'h01);
    // R2 hold: capture 005, pins move to 7FF while select low
    ce_n = 1'b1; addr = 11'h005; @(negedge clk);
    ce_n = 1'b0; addr = 11'h7FF; @(negedge clk);
    read_word(w, v);
    check("R2 held address", w, 8'h01);
    // R4/R5 gating
    oe_n = 1'b0; prog_n = 1'b0; #1;
    check("R4 prog_n low vld", {7'b0, dout_vld}, 8'h00);
    check("R5 prog_n low dout", dout, 8'h00);
    oe_n = 1'b1; prog_n = 1'b1; #1;
    check("R4 oe_n high vld", {7'b0, dout_vld}, 8'h00);
    check("R5 oe_n high dout", dout, 8'h00);
    ce_n = 1'b1; oe_n = 1'b0; #1;
    check("R4 same-cycle vld", {7'b0, dout_vld}, 8'h01);
    @(negedge clk);
    check("R4 ce high vld", {7'b0, dout_vld}, 8'h00);
    check("R5 ce high dout", dout, 8'h00);
    oe_n = 1'b1;

    // Vector table: program attempt, error pulse, read back.
    for (int i = 0; i < NV; i++) begin
      logic [10:0] va;
      va = VEC[i][29:19];
      capture(va);
      oe_n = VEC[i][10]; prog_n = VEC[i][9];
      prog_req = 1'b1; prog_mask = VEC[i][18:11];
      @(negedge clk);
      prog_req = 1'b0; prog_mask = '0; oe_n = 1'b1; prog_n = 1'b1;
      check($sformatf("R10 err vec%0d", i), {7'b0, prog_err}, {7'b0, VEC[i][8]});
      @(negedge clk);
      check($sformatf("R10 err drop vec%0d", i), {7'b0, prog_err}, 8'h00);
      read_word(w, v);
      check($sformatf("R6 word vec%0d", i), w, VEC[i][7:0]);
    end

    // R7 other words untouched
    capture(11'h124); read_word(w, v); check("R7 word 124", w, 8'h10);
    capture(11'h133); read_word(w, v); check("R7 word 133", w, 8'h20);
    capture(11'h113); read_word(w, v); check("R7 word 113", w, 8'h00);

    // R1 reset restores the image
    do_reset();
    capture(11'h123); read_word(w, v); check("R1 word 123 after reset", w, 8'h00);
    capture(11'h005); read_word(w, v); check("R1 word 005 after reset", w, 8'h01);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule